// File: doc/BRIEF.md
# Display Line Scanner with Start-Line Scroll

This block produces the row address sequence that refreshes an LCD driver from a display memory of 64 lines, each 128 bits wide. A host command loads a 6-bit start-line register. That value chooses which memory line is shown on the top common row, so changing it scrolls the picture vertically. Each change of the frame marker loads the line counter from this register. The counter then steps forward on every line pulse and wraps from 63 back to 0, so scrolled content reappears at the bottom.

The memory line at the current address is captured into a 128-bit latch when the line pulse rises. The latch is copied to the driver outputs when the line pulse falls. The line pulse and the frame marker arrive from outside the clock domain. Each passes through a two-flop synchronizer before its edges are detected.

A small controller sequences the work. It has three states:
- `SCAN_IDLE`: no frame marker change has been seen since reset.
- `SCAN_WAIT_RISE`: waiting for a line pulse to rise.
- `SCAN_WAIT_FALL`: a line is held in the latch, waiting for the pulse to fall.

It has three transitions:
- `T_FRAME_START`: `SCAN_IDLE` to `SCAN_WAIT_RISE` on the first frame marker change.
- `T_CAPTURE`: `SCAN_WAIT_RISE` to `SCAN_WAIT_FALL` on a line pulse rise.
- `T_PRESENT`: `SCAN_WAIT_FALL` to `SCAN_WAIT_RISE` on a line pulse fall.

Every input edge is acted on three clock cycles after the pin changes.

Top module: `lcd_line_scan`

## Requirements
- R1: After reset, `line_addr` is 0, `seg_data` is all zeros and the controller is in `SCAN_IDLE`.
- R2: Before the first frame marker change, line pulses leave `line_addr` and `seg_data` unchanged.
- R3: A cycle with `start_we` high stores `start_line` into the 6-bit start register. The register holds that value until the next such write.
- R4: Each change of `frame_mark`, rising or falling, loads `line_addr` with the start register value three clock cycles after the pin changes.
- R5: While scanning, each rising edge of `line_pulse` advances `line_addr` by one, modulo 64, so 63 is followed by 0. `line_addr` changes on no other event.
- R6: A rising edge of `line_pulse` captures `line_rdata` (the memory line at the current `line_addr`) into the latch. `seg_data` does not change while the pulse stays high.
- R7: A falling edge of `line_pulse` after a capture copies the latch to `seg_data`. `seg_data` changes at no other time.
- R8: A start-line write in the middle of a frame does not change the ongoing scan. It takes effect at the next frame marker change.
- R9: With start value S, the k-th line presented after a frame marker change (k counted from 0) equals memory line (S+k) mod 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_we | input | 1 | Host write strobe for the start-line register |
| start_line | input | 6 | Start-line value to store |
| frame_mark | input | 1 | Frame marker, asynchronous; either edge starts a frame |
| line_pulse | input | 1 | Line pulse, asynchronous |
| line_addr | output | 6 | Display memory line address |
| line_rdata | input | 128 | Memory line at `line_addr`, valid in the same cycle |
| seg_data | output | 128 | Line data presented to the driver |

## Verification
The assertions assume that a frame marker change never reaches the edge detector in the same cycle as a line pulse edge. They also assume that every level on `line_pulse` and `frame_mark` lasts longer than the three-cycle synchronizer delay, so no edge is lost. The stimulus keeps every pulse phase six clocks long and lets each frame marker change settle before the next line pulse starts. It also models the memory as a combinational function of `line_addr`, so `line_rdata` always matches the current address.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

    localparam int SCAN_ADDR_W = 6;
    localparam int SCAN_DATA_W = 128;
    localparam int SCAN_SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        SCAN_IDLE      = 2'd0,
        SCAN_WAIT_RISE = 2'd1,
        SCAN_WAIT_FALL = 2'd2
    } scan_state_t;

endpackage

// File: rtl/scan_edge_sync.sv
module scan_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise,
    output logic fall
);

    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= async_in;
    end

    genvar gi;
    generate
        for (gi = 1; gi < CHAIN_W; gi++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain[gi] <= 1'b0;
                else        chain[gi] <= chain[gi-1];
            end
        end
    endgenerate

    // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
    assign rise = chain[STAGES-1] & ~chain[STAGES];
    assign fall = ~chain[STAGES-1] & chain[STAGES];

endmodule

// File: rtl/scan_line_ctrl.sv
module scan_line_ctrl
    import lcd_scan_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_we,
    input  logic [ADDR_W-1:0] start_din,
    input  logic              flm_edge,
    input  logic              lp_rise,
    input  logic              lp_fall,
    output logic [ADDR_W-1:0] start_q,
    output logic [ADDR_W-1:0] line_cnt,
    output logic              capture_en,
    output logic              present_en,
    output scan_state_t       state
);

    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    scan_state_t state_nx;

    // start-line register: only read when a frame begins
    always_ff @(posedge clk) begin
        if (!rst_n)        start_q <= '0;
        else if (start_we) start_q <= start_din;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SCAN_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            SCAN_IDLE:      if (flm_edge) state_nx = SCAN_WAIT_RISE;  // T_FRAME_START
            SCAN_WAIT_RISE: if (lp_rise)  state_nx = SCAN_WAIT_FALL;  // T_CAPTURE
            SCAN_WAIT_FALL: if (lp_fall)  state_nx = SCAN_WAIT_RISE;  // T_PRESENT
            default:                      state_nx = SCAN_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        capture_en = 1'b0;
        present_en = 1'b0;
        unique case (state)
            SCAN_IDLE:      ;
            SCAN_WAIT_RISE: capture_en = lp_rise;
            SCAN_WAIT_FALL: present_en = lp_fall;
            default:        ;
        endcase
    end

    // line counter: frame preset has priority over advance
    always_ff @(posedge clk) begin
        if (!rst_n)          line_cnt <= '0;
        else if (flm_edge)   line_cnt <= start_q;
        else if (capture_en) line_cnt <= line_cnt + ONE;
    end

endmodule

// File: rtl/scan_line_latch.sv
module scan_line_latch #(
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_en,
    input  logic              present_en,
    input  logic [DATA_W-1:0] line_in,
    output logic [DATA_W-1:0] line_out
);

    logic [DATA_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (!rst_n)          hold_q <= '0;
        else if (capture_en) hold_q <= line_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)          line_out <= '0;
        else if (present_en) line_out <= hold_q;
    end

endmodule

// File: rtl/lcd_line_scan.sv
module lcd_line_scan
    import lcd_scan_pkg::*;
#(
    parameter int ADDR_W = SCAN_ADDR_W,
    parameter int DATA_W = SCAN_DATA_W,
    parameter int SYNC_STAGES = SCAN_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_we,
    input  logic [ADDR_W-1:0] start_line,
    input  logic              frame_mark,
    input  logic              line_pulse,
    output logic [ADDR_W-1:0] line_addr,
    input  logic [DATA_W-1:0] line_rdata,
    output logic [DATA_W-1:0] seg_data
);

    logic        flm_rise, flm_fall, flm_edge;
    logic        lp_rise, lp_fall;
    logic        capture_en, present_en;
    logic [ADDR_W-1:0] start_q;
    scan_state_t scan_state;

    scan_edge_sync #(.STAGES(SYNC_STAGES)) u_flm_sync (
        .clk(clk), .rst_n(rst_n), .async_in(frame_mark),
        .rise(flm_rise), .fall(flm_fall)
    );

    scan_edge_sync #(.STAGES(SYNC_STAGES)) u_lp_sync (
        .clk(clk), .rst_n(rst_n), .async_in(line_pulse),
        .rise(lp_rise), .fall(lp_fall)
    );

    assign flm_edge = flm_rise | flm_fall;

    scan_line_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .start_we(start_we), .start_din(start_line),
        .flm_edge(flm_edge), .lp_rise(lp_rise), .lp_fall(lp_fall),
        .start_q(start_q), .line_cnt(line_addr),
        .capture_en(capture_en), .present_en(present_en),
        .state(scan_state)
    );

    scan_line_latch #(.DATA_W(DATA_W)) u_latch (
        .clk(clk), .rst_n(rst_n),
        .capture_en(capture_en), .present_en(present_en),
        .line_in(line_rdata), .line_out(seg_data)
    );

endmodule

// File: rtl/lcd_line_scan_chk.sv
module lcd_line_scan_chk
    import lcd_scan_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_we,
    input  logic              flm_edge,
    input  logic              lp_rise,
    input  logic              lp_fall,
    input  logic [ADDR_W-1:0] start_q,
    input  logic [ADDR_W-1:0] line_addr,
    input  logic [DATA_W-1:0] seg_data,
    input  scan_state_t       scan_state
);

    AST_PRESET_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        flm_edge |=> line_addr == $past(start_q));  // R4

    AST_ADVANCE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_rise && !flm_edge && scan_state == SCAN_WAIT_RISE)
            |=> line_addr == ADDR_W'($past(line_addr) + 1'b1));  // R5

    AST_ADDR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!lp_rise && !flm_edge) |=> $stable(line_addr));  // R5

    AST_IDLE_NO_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_state == SCAN_IDLE && !flm_edge) |=> ($stable(line_addr) && $stable(seg_data)));  // R2

    AST_OUT_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !lp_fall |=> $stable(seg_data));  // R7

    AST_START_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !start_we |=> $stable(start_q));  // R3

endmodule

bind lcd_line_scan lcd_line_scan_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_we(start_we),
    .flm_edge(flm_edge), .lp_rise(lp_rise), .lp_fall(lp_fall),
    .start_q(start_q), .line_addr(line_addr), .seg_data(seg_data),
    .scan_state(scan_state)
);

// File: tb/lcd_line_scan_test.sv
module lcd_line_scan_test;

    localparam int AW = 6;
    localparam int DW = 128;
    localparam int PHASE = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_we = 1'b0;
    logic [AW-1:0] start_line = '0;
    logic          frame_mark = 1'b0;
    logic          line_pulse = 1'b0;
    logic [AW-1:0] line_addr;
    logic [DW-1:0] line_rdata;
    logic [DW-1:0] seg_data;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    function automatic logic [DW-1:0] line_of(input logic [AW-1:0] a);
        return {16{2'b10, a}} ^ {8{16'h5A3C}};
    endfunction

    assign line_rdata = line_of(line_addr);

    lcd_line_scan uut (
        .clk(clk), .rst_n(rst_n), .start_we(start_we), .start_line(start_line),
        .frame_mark(frame_mark), .line_pulse(line_pulse), .line_addr(line_addr),
        .line_rdata(line_rdata), .seg_data(seg_data)
    );

    // {start value, number of lines}
    localparam logic [11:0] VEC [5] = '{
        {6'd0,  6'd5},
        {6'd5,  6'd4},
        {6'd62, 6'd4},
        {6'd63, 6'd3},
        {6'd31, 6'd2}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_start(input logic [AW-1:0] v);
        start_line = v; start_we = 1'b1;
        tick(1);
        start_we = 1'b0;
    endtask

    task automatic new_frame();
        frame_mark = ~frame_mark;
        tick(PHASE);
    endtask

    task automatic line_cycle();
        line_pulse = 1'b1; tick(PHASE);
        line_pulse = 1'b0; tick(PHASE);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check("R1 addr", DW'(line_addr), '0);
        check("R1 seg", seg_data, '0);

        // line pulses before any frame marker change
        line_cycle(); line_cycle();
        check("R2 addr", DW'(line_addr), '0);
        check("R2 seg", seg_data, '0);

        // table of frames
        for (int v = 0; v < 5; v++) begin
            logic [AW-1:0] s;
            int n;
            s = VEC[v][11:6];
            n = int'(VEC[v][5:0]);
            write_start(s);
            new_frame();
            check("R4 R3 preset", DW'(line_addr), DW'(s));
            for (int k = 0; k < n; k++) begin
                line_cycle();
                check("R9 line", seg_data, line_of(AW'(s + k)));
                check("R5 advance", DW'(line_addr), DW'(AW'(s + k + 1)));
            end
        end

        // capture on rise, present on fall
        write_start(6'd20);
        new_frame();
        line_cycle();
        check("R7 first", seg_data, line_of(6'd20));
        line_pulse = 1'b1; tick(PHASE);
        check("R6 hold while high", seg_data, line_of(6'd20));
        line_pulse = 1'b0; tick(PHASE);
        check("R7 after fall", seg_data, line_of(6'd21));

        // mid-frame write
        write_start(6'd10);
        new_frame();
        line_cycle(); line_cycle();
        write_start(6'd40);
        line_cycle(); line_cycle();
        check("R8 old scan", seg_data, line_of(6'd13));
        check("R8 old addr", DW'(line_addr), DW'(6'd14));
        new_frame();
        check("R8 new preset", DW'(line_addr), DW'(6'd40));
        line_cycle();
        check("R8 new line", seg_data, line_of(6'd40));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule